// File: doc/BRIEF.md
# Dual-Output Serial Audio Transmitter

This block turns stereo sample pairs into a continuous serial audio stream. It divides the system clock down to an internal bit clock. Each frame has 64 bit clocks: 32 slots for the left word, then 32 for the right. A word-select line marks which channel is on the wire. A two-bit selector picks one of four bit alignments inside each half-frame. The same serial bit is driven onto a primary output and a secondary output, so both carry the same timing and format.

Samples arrive through a valid/ready handshake. The block takes a new pair only at a frame boundary, and sends silence when nothing is offered. A primary enable gates the primary output, and it also acts as the master gate for the secondary output and the serial clock pin. The serial clock pin can be switched off on its own, for receivers that recover their own bit clock, while data keeps flowing.

Top module: `sat_tx`

## Requirements
- R1: With `fmt` = 2'b00, the MSB of each channel word is sent in slot 1 of its half-frame, one bit clock after the word-select change. The remaining bits follow MSB first in slots 2..20, and slot 0 and slots 21..31 carry 0.
- R2: With `fmt` = 2'b01, the MSB is sent in slot 0, the slot in which word-select changes, and the bits follow in slots 0..19. Slots 20..31 carry 0.
- R3: With `fmt` = 2'b10, all 20 sample bits are right-aligned, so bit 0 is sent in slot 31 and bit 19 in slot 12. Slots 0..11 carry 0.
- R4: With `fmt` = 2'b11, only sample bits 19..4 are sent, right-aligned with bit 4 in slot 31. Slots 0..15 carry 0.
- R5: `ws` is 0 for the 32 slots of the left word and 1 for the 32 slots of the right word, and it changes only together with a falling bit clock.
- R6: Serial data changes only on the system clock edge at which the bit clock falls, so it is stable when the bit clock rises.
- R7: While `en_pri` is 0, `sd_pri`, `sd_sec` and `sclk` are all held at 0.
- R8: `sd_sec` equals `sd_pri` while `en_pri` and `en_sec` are both 1, and it is 0 otherwise.
- R9: `sclk` toggles only while `en_clk` and `en_pri` are both 1. With `en_clk` at 0 it stays 0 and serial data continues.
- R10: `in_ready` is high for exactly one system clock per frame, every 128*HALF_DIV clocks, in the cycle before slot 0 of a left half begins. A pair is taken when `in_valid` is high in that cycle; otherwise the frame carries all zeros.
- R11: During reset, `sd_pri`, `sd_sec`, `sclk` and `in_ready` are 0 and `ws` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt | input | 2 | Alignment select (00, 01, 10, 11 as in R1..R4) |
| en_pri | input | 1 | Primary output enable, master gate |
| en_sec | input | 1 | Secondary output enable |
| en_clk | input | 1 | Serial clock pin enable |
| in_valid | input | 1 | Sample pair offered |
| in_left | input | SAMPLE_W | Left sample |
| in_right | input | SAMPLE_W | Right sample |
| in_ready | output | 1 | Pair taken at the next clock edge |
| sd_pri | output | 1 | Primary serial data |
| sd_sec | output | 1 | Secondary serial data |
| ws | output | 1 | Word select, low for left |
| sclk | output | 1 | Gated serial bit clock |

## Verification
Each slot's bit and `ws` are registered on the same clock edge that drops the internal bit clock, so both become visible together with the falling `sclk`. The bench samples them at the falling system-clock edge that follows the next rising `sclk`. `in_ready` is combinational and high in the cycle before the load edge. The bench therefore records the offered pair at the falling edge inside that cycle and expects slot 0 at the very next rising `sclk`. The enable gates act with no added delay, so the gating checks sample every falling system-clock edge across windows several frames long.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [1:0] {
    FMT_I2S  = 2'b00,
    FMT_LJ   = 2'b01,
    FMT_RJW  = 2'b10,
    FMT_RJ16 = 2'b11
  } fmt_e;
endpackage

// File: rtl/sat_bclk_gen.sv
module sat_bclk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic bclk,
  output logic fall_tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          bclk_q, bclk_d;
  logic          edge_tick;

  always_comb begin
    edge_tick = (cnt_q == CW'(HALF_DIV - 1));
    cnt_d     = edge_tick ? '0 : cnt_q + 1'b1;
    bclk_d    = edge_tick ? ~bclk_q : bclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bclk_q <= bclk_d;
    end
  end

  assign bclk      = bclk_q;
  assign fall_tick = edge_tick & bclk_q;
endmodule

// File: rtl/sat_frame_ctl.sv
module sat_frame_ctl #(
  parameter int SAMPLE_W = 20,
  parameter int SLOT_W   = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fall_tick,
  input  logic                          in_valid,
  input  logic [SAMPLE_W-1:0]           in_left,
  input  logic [SAMPLE_W-1:0]           in_right,
  output logic                          in_ready,
  output logic [$clog2(SLOT_W):0]       nxt_slot,
  output logic [SAMPLE_W-1:0]           nxt_word
);
  localparam int SB = $clog2(SLOT_W) + 1;

  logic [SB-1:0]       slot_q, slot_d;
  logic [SAMPLE_W-1:0] left_q, left_d, right_q, right_d;
  logic                load;

  always_comb begin
    load    = fall_tick & (&slot_q);
    slot_d  = fall_tick ? slot_q + 1'b1 : slot_q;
    left_d  = left_q;
    right_d = right_q;
    if (load) begin
      left_d  = in_valid ? in_left  : '0;
      right_d = in_valid ? in_right : '0;
    end
    nxt_word = slot_d[SB-1] ? right_d : left_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '1;
      left_q  <= '0;
      right_q <= '0;
    end else begin
      slot_q  <= slot_d;
      left_q  <= left_d;
      right_q <= right_d;
    end
  end

  assign in_ready = load;
  assign nxt_slot = slot_d;

  // R10: the handshake window is never wider than one clock
  p_ready_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);
  // R10: a load restarts the slot count at the first left slot
  p_load_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (slot_q == '0));
endmodule

// File: rtl/sat_bit_pick.sv
module sat_bit_pick #(
  parameter int SAMPLE_W = 20,
  parameter int SLOT_W   = 32
) (
  input  sat_pkg::fmt_e                 fmt,
  input  logic [$clog2(SLOT_W)-1:0]     pos,
  input  logic [SAMPLE_W-1:0]           word,
  output logic                          bit_o
);
  localparam int SHORT_W = 16;

  int k;
  int idx;

  always_comb begin
    k = int'(pos);
    unique case (fmt)
      sat_pkg::FMT_I2S:  idx = SAMPLE_W - k;
      sat_pkg::FMT_LJ:   idx = SAMPLE_W - 1 - k;
      sat_pkg::FMT_RJW:  idx = SLOT_W - 1 - k;
      default:           idx = (SLOT_W - 1 - k) + (SAMPLE_W - SHORT_W);
    endcase
    bit_o = 1'b0;
    for (int i = 0; i < SAMPLE_W; i++) begin
      if (idx == i) bit_o = word[i];
    end
  end
endmodule

// File: rtl/sat_tx.sv
module sat_tx #(
  parameter int SAMPLE_W = 20,
  parameter int SLOT_W   = 32,
  parameter int HALF_DIV = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          fmt,
  input  logic                en_pri,
  input  logic                en_sec,
  input  logic                en_clk,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  output logic                in_ready,
  output logic                sd_pri,
  output logic                sd_sec,
  output logic                ws,
  output logic                sclk
);
  localparam int PW = $clog2(SLOT_W);
  localparam int SB = PW + 1;

  logic [1:0]          rs_q;
  logic                rst_core_n;
  logic                bclk, fall_tick;
  logic [SB-1:0]       nxt_slot;
  logic [SAMPLE_W-1:0] nxt_word;
  logic                pick;
  logic                bit_q, bit_d, ws_q, ws_d;
  sat_pkg::fmt_e       fmt_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  assign fmt_sel = sat_pkg::fmt_e'(fmt);

  sat_bclk_gen #(.HALF_DIV(HALF_DIV)) u_bclk (
    .clk(clk), .rst_n(rst_core_n), .bclk(bclk), .fall_tick(fall_tick)
  );

  sat_frame_ctl #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_frame (
    .clk(clk), .rst_n(rst_core_n), .fall_tick(fall_tick),
    .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .in_ready(in_ready), .nxt_slot(nxt_slot), .nxt_word(nxt_word)
  );

  sat_bit_pick #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_pick (
    .fmt(fmt_sel), .pos(nxt_slot[PW-1:0]), .word(nxt_word), .bit_o(pick)
  );

  always_comb begin
    bit_d = fall_tick ? pick : bit_q;
    ws_d  = fall_tick ? nxt_slot[SB-1] : ws_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      bit_q <= 1'b0;
      ws_q  <= 1'b1;
    end else begin
      bit_q <= bit_d;
      ws_q  <= ws_d;
    end
  end

  assign sd_pri = en_pri & bit_q;
  assign sd_sec = en_pri & en_sec & bit_q;
  assign sclk   = en_pri & en_clk & bclk;
  assign ws     = ws_q;

  // R6: serial data moves only with a falling bit clock
  p_data_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bit_q != $past(bit_q)) |-> (!bclk && $past(bclk)));
  // R5: word select moves only with a falling bit clock
  p_ws_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ws_q != $past(ws_q)) |-> (!bclk && $past(bclk)));
  // R8: secondary data never shows a 1 that the primary lacks
  p_sec_within_pri_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    sd_sec |-> sd_pri);
  // R10: a taken pair starts with the left half
  p_left_after_load_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    in_ready |=> !ws_q);
endmodule

// File: tb/sim_sat_tx.sv
`timescale 1ns/1ps
module sim_sat_tx;
  localparam int SW = 20;
  localparam int HD = 2;
  localparam int FRAME_CLK = 128 * HD;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    fmt;
  logic          en_pri, en_sec, en_clk, in_valid;
  logic [SW-1:0] in_left, in_right;
  logic          in_ready, sd_pri, sd_sec, ws, sclk;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sat_tx #(.SAMPLE_W(SW), .SLOT_W(32), .HALF_DIV(HD)) u0 (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .en_pri(en_pri), .en_sec(en_sec),
    .en_clk(en_clk), .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .in_ready(in_ready), .sd_pri(sd_pri), .sd_sec(sd_sec), .ws(ws), .sclk(sclk)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [1:0] f, input logic [SW-1:0] w, input int k);
    logic [31:0] h;
    case (f)
      2'b00:   h = {1'b0, w, 11'b0};
      2'b01:   h = {w, 12'b0};
      2'b10:   h = {12'b0, w};
      default: h = {16'b0, w[19:4]};
    endcase
    return h[31-k];
  endfunction

  function automatic logic [SW-1:0] pat(input int p, input bit right);
    case (p)
      0: return right ? 20'h00001 : 20'hFFFFF;
      1: return right ? 20'hABCDE : 20'h80000;
      2: return right ? 20'h0F0F0 : 20'h12345;
      default: return right ? 20'h7FFFE : 20'h5A5A5;
    endcase
  endfunction

  // frame monitor
  bit            mon_on = 1'b0;
  bit            active = 1'b0;
  bit            prev_sclk = 1'b0, prev_sd = 1'b0;
  int            nbits = 0, err_d = 0, err_ws = 0, err_sec = 0, stab_err = 0;
  bit            cur_zero;
  logic [1:0]    cur_fmt;
  logic [SW-1:0] cur_l, cur_r;
  longint        cyc = 0, last_rdy = -1;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (sd_pri != prev_sd && !(prev_sclk && !sclk)) stab_err++;
      if (in_ready) begin
        if (active && nbits == 64) begin
          if (cur_zero) chk(err_d == 0, "R10", "idle frame not all zero", err_d, 0);
          else case (cur_fmt)
            2'b00: chk(err_d == 0, "R1", "I2S bit mismatches", err_d, 0);
            2'b01: chk(err_d == 0, "R2", "left-justified bit mismatches", err_d, 0);
            2'b10: chk(err_d == 0, "R3", "right-justified wide mismatches", err_d, 0);
            default: chk(err_d == 0, "R4", "right-justified 16 mismatches", err_d, 0);
          endcase
          chk(err_ws == 0, "R5", "word select mismatches", err_ws, 0);
          chk(err_sec == 0, "R8", "secondary differs from primary", err_sec, 0);
        end
        if (last_rdy >= 0)
          chk(cyc - last_rdy == FRAME_CLK, "R10", "ready interval",
              int'(cyc - last_rdy), FRAME_CLK);
        last_rdy = cyc;
        cur_zero = !in_valid;
        cur_l    = in_valid ? in_left  : '0;
        cur_r    = in_valid ? in_right : '0;
        cur_fmt  = fmt;
        active   = 1'b1;
        nbits    = 0; err_d = 0; err_ws = 0; err_sec = 0;
      end else if (sclk && !prev_sclk && active && nbits < 64) begin
        if (sd_pri !== exp_bit(cur_fmt, (nbits < 32) ? cur_l : cur_r, nbits % 32)) err_d++;
        if (ws !== (nbits >= 32)) err_ws++;
        if (sd_sec !== sd_pri) err_sec++;
        nbits++;
      end
    end
    prev_sclk = sclk;
    prev_sd   = sd_pri;
  end

  task automatic send(input logic [SW-1:0] l, input logic [SW-1:0] r);
    in_valid = 1'b1; in_left = l; in_right = r;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
  endtask

  task automatic idle();
    in_valid = 1'b0;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
  endtask

  int w_sclk_hi, w_tog, w_pri_hi, w_sec_hi, w_mis, w_any;
  task automatic window(input int n);
    logic last;
    w_sclk_hi = 0; w_tog = 0; w_pri_hi = 0; w_sec_hi = 0; w_mis = 0; w_any = 0;
    @(negedge clk); last = sd_pri;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sclk) w_sclk_hi++;
      if (sd_pri != last) w_tog++;
      if (sd_pri) w_pri_hi++;
      if (sd_sec) w_sec_hi++;
      if (sd_sec != sd_pri) w_mis++;
      if (sd_pri | sd_sec | sclk) w_any++;
      last = sd_pri;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; fmt = 2'b00; en_pri = 1'b1; en_sec = 1'b1; en_clk = 1'b1;
    in_valid = 1'b0; in_left = '0; in_right = '0;
    repeat (5) @(negedge clk);
    chk(sd_pri == 1'b0 && sd_sec == 1'b0, "R11", "data in reset", sd_pri + sd_sec, 0);
    chk(sclk == 1'b0, "R11", "sclk in reset", sclk, 0);
    chk(ws == 1'b1, "R11", "ws in reset", ws, 1);
    chk(in_ready == 1'b0, "R11", "ready in reset", in_ready, 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    for (int f = 0; f < 4; f++) begin
      idle();
      fmt = 2'(f);
      for (int p = 0; p < 4; p++) send(pat(p, 1'b0), pat(p, 1'b1));
    end
    idle();
    idle();
    mon_on = 1'b0;
    chk(stab_err == 0, "R6", "data moved off a falling sclk", stab_err, 0);

    fmt = 2'b01; in_valid = 1'b1; in_left = 20'hAAAAA; in_right = 20'h55555;
    en_clk = 1'b0;
    window(3 * FRAME_CLK);
    chk(w_sclk_hi == 0, "R9", "sclk high with clock disabled", w_sclk_hi, 0);
    chk(w_tog > 0, "R9", "data stalled with clock disabled", w_tog, 1);
    en_clk = 1'b1;
    window(FRAME_CLK);
    chk(w_sclk_hi > 0, "R9", "sclk silent with clock enabled", w_sclk_hi, 1);

    en_pri = 1'b0;
    window(3 * FRAME_CLK);
    chk(w_any == 0, "R7", "outputs active with primary disabled", w_any, 0);

    en_pri = 1'b1; en_sec = 1'b0;
    window(2 * FRAME_CLK);
    chk(w_sec_hi == 0, "R8", "secondary high while disabled", w_sec_hi, 0);
    chk(w_pri_hi > 0, "R8", "primary silent while secondary off", w_pri_hi, 1);
    en_sec = 1'b1;
    window(2 * FRAME_CLK);
    chk(w_mis == 0 && w_pri_hi > 0, "R8", "secondary differs from primary", w_mis, 0);

    summary();
    $finish;
  end
endmodule